// File: doc/BRIEF.md
# Programmable Interlaced Display Timing Generator

This block produces the vertical frame timing for a raw-mode video output port that shows two interlaced fields per frame. A free-running pixel counter and a frame line counter walk the raster. The block compares them against programmed pixel/line pairs to drive a vertical-blank flag, a vertical-sync flag and a field indicator. Because each edge is a pixel and line pair, the edges of the second field can fall in the middle of a line, which gives half-line interlace.

For every active pixel it decides whether the position lies inside the image window of the current field. Each field has its own window offset and height. Inside the window the block pops a pixel from a show-ahead FIFO and presents it. Everywhere else it presents a programmable default value, because raw mode has no blanking code. Software programs every timing value through a simple write port. One shared output pin carries a selectable timing signal, and a polarity bit can make the timing outputs active-low.

Top module: `ilace_tgen`

## Requirements
- R1: While the run bit is set, the pixel counter counts 0 up to line length minus 1 and then wraps to 0. Each wrap advances the line counter, and a wrap on a line at or above the frame height returns it to line 1. While the run bit is clear, the counters sit at pixel 0, line 1. A field therefore repeats every line length times frame height clocks.
- R2: The vertical-blank flag becomes active one clock after the counters equal either blank start pair and becomes inactive one clock after they equal either blank stop pair. When a set pair and a clear pair match together, the clear wins.
- R3: The vertical-sync flag follows the same rule using its own two start pairs and two stop pairs.
- R4: The field indicator goes to 1 one clock after the counters equal the field-2 pair. It goes to 0 one clock after they equal the field-1 pair.
- R5: With the active-low bit (control bit 1) set, vblank, vsync and ctl_pin are inverted. field_id is never inverted.
- R6: ctl_pin carries vsync for select code 0, vblank for code 1, the field indicator for code 2 and an inactive level for code 3 (select code in control bits 3:2).
- R7: img_valid is a register. It is high one clock after a position whose pixel is below the active width and whose line lies in a field window. A field window starts at that field's blank stop line plus that field's offset and spans that field's size in lines.
- R8: fifo_rd is high, in the same cycle, exactly when the run bit is set, the current position is inside a window per R7 and fifo_empty is low.
- R9: pix_data is a register. It takes fifo_data one clock after a cycle with fifo_rd high, and the default value after any other cycle, including while the FIFO is empty inside the window.
- R10: A write on the register port takes effect on the next clock. The map is: 0 control (bit 0 run, bit 1 active-low, bits 3:2 pin select), 1 line length, 2 active width, 3 frame height, 4 default value. Addresses 5 to 12 hold the blank pairs as x then y for start1, stop1, start2, stop2. Addresses 13 to 20 hold the sync pairs in the same order. Addresses 21 to 24 hold the field-1 pair then the field-2 pair. Addresses 25 to 28 hold offset1, size1, offset2, size2. Reset loads a 525-line, 858-pixel, 720-active example with active-low set, run clear and default value 0x040.
- R11: While the run bit is clear, every flag, img_valid and fifo_rd are inactive and pix_data holds the default value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 16 | Register write data |
| fifo_empty | input | 1 | Pixel FIFO has no data |
| fifo_data | input | DATA_W | Head entry of the show-ahead pixel FIFO |
| fifo_rd | output | 1 | Pop strobe for the pixel FIFO |
| pix_data | output | DATA_W | Pixel value for the active portion of the line |
| img_valid | output | 1 | Current output pixel lies in the image window |
| vblank | output | 1 | Vertical blank, polarity per control |
| vsync | output | 1 | Vertical sync, polarity per control |
| field_id | output | 1 | Field indicator, 1 during field 2 |
| ctl_pin | output | 1 | Shared control pin, selected signal with polarity |

## Verification
The bench aims at edges that fall mid-line, at a set pair equal to its own clear pair, at windows that run past the frame height or have zero size, and at reprogramming while the raster runs. A design that compared against the wrong pair would move a field-2 edge by half a line. A design that let the set win a collision would leave sync stuck active. A design that read the FIFO while it was empty, or outside the window, would pop garbage or shift every following pixel. Stopping and restarting the raster checks that all flags fall back to their idle levels. Comparing the period of the field indicator checks wrap handling, because an off-by-one in either counter stretches every field.

// File: rtl/ilace_pkg.sv
package ilace_pkg;

    parameter int REG_W  = 16;
    parameter int NREG   = 29;
    parameter int ADDR_W = 5;

    typedef struct packed {
        logic [REG_W-1:0] x;
        logic [REG_W-1:0] y;
    } pt_t;

    // blk/syn index: 0 start1, 1 stop1, 2 start2, 3 stop2; fld: 0 field1, 1 field2
    typedef struct packed {
        logic             run;
        logic             act_low;
        logic [1:0]       pin_sel;
        logic [REG_W-1:0] line_len;
        logic [REG_W-1:0] act_w;
        logic [REG_W-1:0] frame_h;
        logic [REG_W-1:0] def_val;
        pt_t [3:0]        blk;
        pt_t [3:0]        syn;
        pt_t [1:0]        fld;
        logic [REG_W-1:0] off1;
        logic [REG_W-1:0] size1;
        logic [REG_W-1:0] off2;
        logic [REG_W-1:0] size2;
    } cfg_t;

    function automatic logic [REG_W-1:0] rst_val(input int a);
        int v;
        case (a)
            0:  v = 2;
            1:  v = 858;
            2:  v = 720;
            3:  v = 525;
            4:  v = 'h040;
            5:  v = 720;  6:  v = 1;
            7:  v = 720;  8:  v = 21;
            9:  v = 360;  10: v = 263;
            11: v = 360;  12: v = 283;
            13: v = 720;  14: v = 4;
            15: v = 720;  16: v = 7;
            17: v = 360;  18: v = 266;
            19: v = 360;  20: v = 269;
            21: v = 720;  22: v = 1;
            23: v = 360;  24: v = 263;
            25: v = 2;    26: v = 240;
            27: v = 3;    28: v = 240;
            default: v = 0;
        endcase
        return REG_W'(v);
    endfunction

endpackage

// File: rtl/ilace_cfg_regs.sv
module ilace_cfg_regs
    import ilace_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output cfg_t              cfg
);

    logic [REG_W-1:0] regs_d [NREG];
    logic [REG_W-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (cfg_we && (int'(cfg_addr) < NREG)) regs_d[cfg_addr] = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= rst_val(i);
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        cfg.run      = regs_q[0][0];
        cfg.act_low  = regs_q[0][1];
        cfg.pin_sel  = regs_q[0][3:2];
        cfg.line_len = regs_q[1];
        cfg.act_w    = regs_q[2];
        cfg.frame_h  = regs_q[3];
        cfg.def_val  = regs_q[4];
        for (int k = 0; k < 4; k++) begin
            cfg.blk[k].x = regs_q[5 + 2*k];
            cfg.blk[k].y = regs_q[6 + 2*k];
            cfg.syn[k].x = regs_q[13 + 2*k];
            cfg.syn[k].y = regs_q[14 + 2*k];
        end
        for (int k = 0; k < 2; k++) begin
            cfg.fld[k].x = regs_q[21 + 2*k];
            cfg.fld[k].y = regs_q[22 + 2*k];
        end
        cfg.off1  = regs_q[25];
        cfg.size1 = regs_q[26];
        cfg.off2  = regs_q[27];
        cfg.size2 = regs_q[28];
    end

    logic unused_ctrl;
    assign unused_ctrl = ^regs_q[0][REG_W-1:4];

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == '0) |=> (cfg.run == $past(cfg_wdata[0]))); // R10

endmodule

// File: rtl/ilace_pos_cnt.sv
module ilace_pos_cnt
    import ilace_pkg::*;
#(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [REG_W-1:0]  line_len,
    input  logic [REG_W-1:0]  frame_h,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] line
);

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [LINE_W-1:0] line;
    } st_t;

    st_t st_d, st_q;
    logic eol, eof;

    always_comb begin
        st_d = st_q;
        eol  = REG_W'(st_q.pix) >= (line_len - REG_W'(1));
        eof  = REG_W'(st_q.line) >= frame_h;
        if (!run) begin
            st_d.pix  = '0;
            st_d.line = LINE_W'(1);
        end else if (eol) begin
            st_d.pix  = '0;
            st_d.line = eof ? LINE_W'(1) : st_q.line + LINE_W'(1);
        end else begin
            st_d.pix  = st_q.pix + PIX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pix  <= '0;
            st_q.line <= LINE_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign pix  = st_q.pix;
    assign line = st_q.line;

    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && REG_W'(pix) >= line_len - REG_W'(1)) |=> (pix == '0)); // R1
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && REG_W'(pix) >= line_len - REG_W'(1) && REG_W'(line) >= frame_h)
        |=> (line == LINE_W'(1))); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pix == '0 && line == LINE_W'(1))); // R1

endmodule

// File: rtl/ilace_edge_flag.sv
module ilace_edge_flag
    import ilace_pkg::*;
#(
    parameter int NPAIR  = 2,
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [PIX_W-1:0]            pix,
    input  logic [LINE_W-1:0]           line,
    input  logic [NPAIR-1:0][REG_W-1:0] set_x,
    input  logic [NPAIR-1:0][REG_W-1:0] set_y,
    input  logic [NPAIR-1:0][REG_W-1:0] clr_x,
    input  logic [NPAIR-1:0][REG_W-1:0] clr_y,
    output logic                        flag
);

    logic [NPAIR-1:0] hit_set, hit_clr;
    logic flag_d, flag_q;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign hit_set[g] = (REG_W'(pix) == set_x[g]) && (REG_W'(line) == set_y[g]);
        assign hit_clr[g] = (REG_W'(pix) == clr_x[g]) && (REG_W'(line) == clr_y[g]);
    end

    always_comb begin
        flag_d = flag_q;
        if (!en)               flag_d = 1'b0;
        else if (|hit_clr)     flag_d = 1'b0;
        else if (|hit_set)     flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && |hit_clr) |=> !flag); // R2
    AST_SET_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && |hit_set && !(|hit_clr)) |=> flag); // R3
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !flag); // R11

endmodule

// File: rtl/ilace_pix_sel.sv
module ilace_pix_sel
    import ilace_pkg::*;
#(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  logic [REG_W-1:0]  act_w,
    input  logic [REG_W-1:0]  stop_y1,
    input  logic [REG_W-1:0]  off1,
    input  logic [REG_W-1:0]  size1,
    input  logic [REG_W-1:0]  stop_y2,
    input  logic [REG_W-1:0]  off2,
    input  logic [REG_W-1:0]  size2,
    input  logic [DATA_W-1:0] def_val,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic [DATA_W-1:0] data,
    output logic              img
);

    localparam int WW = REG_W + 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              img;
    } st_t;

    st_t st_d, st_q;
    logic [WW-1:0] first1, first2, ln;
    logic in_win1, in_win2, active, in_img;

    always_comb begin
        ln      = WW'(line);
        first1  = WW'(stop_y1) + WW'(off1);
        first2  = WW'(stop_y2) + WW'(off2);
        in_win1 = (ln >= first1) && (ln < first1 + WW'(size1));
        in_win2 = (ln >= first2) && (ln < first2 + WW'(size2));
        active  = REG_W'(pix) < act_w;
        in_img  = en && active && (in_win1 || in_win2);
        fifo_rd = in_img && !fifo_empty;
        st_d.img  = in_img;
        st_d.data = fifo_rd ? fifo_data : def_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.img  <= 1'b0;
            st_q.data <= def_val;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.data;
    assign img  = st_q.img;

    AST_POP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> (data == $past(fifo_data))); // R9
    AST_DEFAULT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rd |=> (data == $past(def_val))); // R9
    AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_rd); // R8

endmodule

// File: rtl/ilace_tgen.sv
module ilace_tgen
    import ilace_pkg::*;
#(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic [DATA_W-1:0] pix_data,
    output logic              img_valid,
    output logic              vblank,
    output logic              vsync,
    output logic              field_id,
    output logic              ctl_pin
);

    cfg_t cfg;
    logic [PIX_W-1:0]  pix;
    logic [LINE_W-1:0] line;
    logic [1:0]        vflag;
    logic              fld;
    logic              pin_raw;
    pt_t [1:0][3:0]    vpts;

    ilace_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    ilace_pos_cnt #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg.run),
        .line_len (cfg.line_len),
        .frame_h  (cfg.frame_h),
        .pix      (pix),
        .line     (line)
    );

    assign vpts[0] = cfg.blk;
    assign vpts[1] = cfg.syn;

    // index 0: vertical blank, index 1: vertical sync
    for (genvar g = 0; g < 2; g++) begin : g_vflag
        ilace_edge_flag #(.NPAIR(2), .PIX_W(PIX_W), .LINE_W(LINE_W)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cfg.run),
            .pix   (pix),
            .line  (line),
            .set_x ({vpts[g][2].x, vpts[g][0].x}),
            .set_y ({vpts[g][2].y, vpts[g][0].y}),
            .clr_x ({vpts[g][3].x, vpts[g][1].x}),
            .clr_y ({vpts[g][3].y, vpts[g][1].y}),
            .flag  (vflag[g])
        );
    end

    ilace_edge_flag #(.NPAIR(1), .PIX_W(PIX_W), .LINE_W(LINE_W)) u_fld (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg.run),
        .pix   (pix),
        .line  (line),
        .set_x (cfg.fld[1].x),
        .set_y (cfg.fld[1].y),
        .clr_x (cfg.fld[0].x),
        .clr_y (cfg.fld[0].y),
        .flag  (fld)
    );

    ilace_pix_sel #(.PIX_W(PIX_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg.run),
        .pix        (pix),
        .line       (line),
        .act_w      (cfg.act_w),
        .stop_y1    (cfg.blk[1].y),
        .off1       (cfg.off1),
        .size1      (cfg.size1),
        .stop_y2    (cfg.blk[3].y),
        .off2       (cfg.off2),
        .size2      (cfg.size2),
        .def_val    (cfg.def_val[DATA_W-1:0]),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .data       (pix_data),
        .img        (img_valid)
    );

    always_comb begin
        case (cfg.pin_sel)
            2'd0:    pin_raw = vflag[1];
            2'd1:    pin_raw = vflag[0];
            2'd2:    pin_raw = fld;
            default: pin_raw = 1'b0;
        endcase
    end

    assign vblank   = vflag[0] ^ cfg.act_low;
    assign vsync    = vflag[1] ^ cfg.act_low;
    assign field_id = fld;
    assign ctl_pin  = pin_raw ^ cfg.act_low;

    logic unused_def;
    assign unused_def = ^cfg.def_val[REG_W-1:DATA_W];

    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.run && !$past(cfg.run)) |-> (ctl_pin == cfg.act_low)); // R11
    AST_FIELD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.run && REG_W'(pix) == cfg.fld[1].x && REG_W'(line) == cfg.fld[1].y
         && !(REG_W'(pix) == cfg.fld[0].x && REG_W'(line) == cfg.fld[0].y))
        |=> field_id); // R4

endmodule

// File: tb/ilace_tgen_test.sv
module ilace_tgen_test;

    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          fifo_empty = 1'b1;
    logic [DW-1:0] fifo_data = '0;
    logic          fifo_rd;
    logic [DW-1:0] pix_data;
    logic          img_valid, vblank, vsync, field_id, ctl_pin;

    always #5 clk = ~clk;

    ilace_tgen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .pix_data(pix_data), .img_valid(img_valid),
        .vblank(vblank), .vsync(vsync), .field_id(field_id), .ctl_pin(ctl_pin)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model state
    logic [15:0] mc [29];
    int mpix, mline;
    bit mvb, mvs, mfld, mimg;
    logic [DW-1:0] mdata;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit at(input int xa, input int ya);
        return (mpix == int'(mc[xa])) && (mline == int'(mc[ya]));
    endfunction

    function automatic bit in_img();
        int f1, f2;
        f1 = int'(mc[8]) + int'(mc[25]);
        f2 = int'(mc[12]) + int'(mc[27]);
        return mc[0][0] && (mpix < int'(mc[2])) &&
               ((mline >= f1 && mline < f1 + int'(mc[26])) ||
                (mline >= f2 && mline < f2 + int'(mc[28])));
    endfunction

    function automatic bit exp_pin();
        bit r;
        case (mc[0][3:2])
            2'd0: r = mvs;
            2'd1: r = mvb;
            2'd2: r = mfld;
            default: r = 1'b0;
        endcase
        return r ^ mc[0][1];
    endfunction

    task automatic model_step();
        bit run, rd;
        run = mc[0][0];
        rd  = in_img() && !fifo_empty;
        if (!run)                      mvb = 0;
        else if (at(7,8) || at(11,12)) mvb = 0;
        else if (at(5,6) || at(9,10))  mvb = 1;
        if (!run)                        mvs = 0;
        else if (at(15,16) || at(19,20)) mvs = 0;
        else if (at(13,14) || at(17,18)) mvs = 1;
        if (!run)           mfld = 0;
        else if (at(21,22)) mfld = 0;
        else if (at(23,24)) mfld = 1;
        mimg  = in_img();
        mdata = rd ? fifo_data : mc[4][DW-1:0];
        if (!run) begin
            mpix = 0; mline = 1;
        end else if (mpix >= int'(mc[1]) - 1) begin
            mpix = 0;
            mline = (mline >= int'(mc[3])) ? 1 : mline + 1;
        end else begin
            mpix++;
        end
    endtask

    // one clock: drive at negedge, check, advance model, optional register write
    task automatic step(input bit we, input int a, input int d);
        string p;
        @(negedge clk);
        cfg_we     = we;
        cfg_addr   = 5'(a);
        cfg_wdata  = 16'(d);
        fifo_empty = ($urandom % 4) == 0;
        fifo_data  = DW'($urandom);
        #1;
        p = mc[0][0] ? "" : "R11 ";
        chk({p, "R2 R5 vblank"}, int'(vblank), int'(mvb ^ mc[0][1]));
        chk({p, "R3 R5 vsync"}, int'(vsync), int'(mvs ^ mc[0][1]));
        chk({p, "R4 field_id"}, int'(field_id), int'(mfld));
        chk({p, "R6 R5 ctl_pin"}, int'(ctl_pin), int'(exp_pin()));
        chk({p, "R7 img_valid"}, int'(img_valid), int'(mimg));
        chk({p, "R8 fifo_rd"}, int'(fifo_rd), int'(in_img() && !fifo_empty));
        chk({p, "R9 pix_data"}, int'(pix_data), int'(mdata));
        model_step();
        if (we && a < 29) mc[a] = 16'(d);
        cyc++;
    endtask

    task automatic wr(input int a, input int d);
        step(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0);
    endtask

    task automatic rand_cfg(input bit run);
        int len, fh;
        len = 6 + int'($urandom % 15);
        fh  = 4 + int'($urandom % 12);
        wr(1, len);
        wr(2, 1 + int'($urandom % len));
        wr(3, fh);
        wr(4, int'($urandom % 1024));
        for (int k = 5; k <= 24; k += 2) begin
            wr(k, int'($urandom % len));
            wr(k + 1, 1 + int'($urandom % fh));
        end
        wr(25, int'($urandom % 4));
        wr(26, int'($urandom % (fh + 1)));
        wr(27, int'($urandom % 4));
        wr(28, int'($urandom % (fh + 1)));
        wr(0, (int'($urandom % 4) << 2) | (int'($urandom % 2) << 1) | int'(run));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int last_rise, rises;
        bit prev_fld;
        void'($urandom(32'd2024));
        for (int i = 0; i < 29; i++) mc[i] = ilace_pkg::rst_val(i);
        mpix = 0; mline = 1; mvb = 0; mvs = 0; mfld = 0; mimg = 0;
        mdata = mc[4][DW-1:0];
        repeat (3) @(posedge clk);
        #2;
        // reset state, R10: idle with active-low default and default data 0x040
        chk("R10 reset vblank", int'(vblank), 1);
        chk("R10 reset vsync", int'(vsync), 1);
        chk("R10 reset ctl_pin", int'(ctl_pin), 1);
        chk("R10 reset field_id", int'(field_id), 0);
        chk("R10 reset pix_data", int'(pix_data), 'h040);
        chk("R10 reset fifo_rd", int'(fifo_rd), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(5);

        // directed: 12-pixel lines, 8 active, 11 lines, mid-line field-2 edges
        wr(1, 12); wr(2, 8); wr(3, 11); wr(4, 'h155);
        wr(5, 8); wr(6, 1); wr(7, 8); wr(8, 3); wr(9, 4); wr(10, 6); wr(11, 4); wr(12, 8);
        // sync field 1: set pair equals clear pair, so clear wins and sync never rises
        wr(13, 8); wr(14, 2); wr(15, 8); wr(16, 2); wr(17, 4); wr(18, 7); wr(19, 0); wr(20, 8);
        wr(21, 8); wr(22, 1); wr(23, 4); wr(24, 6);
        wr(25, 1); wr(26, 2); wr(27, 2); wr(28, 3);
        wr(0, 32'h3);
        last_rise = -1; rises = 0; prev_fld = field_id;
        for (int i = 0; i < 132 * 4; i++) begin
            step(1'b0, 0, 0);
            if (field_id && !prev_fld) begin
                if (last_rise >= 0) chk("R1 field period", cyc - last_rise, 132);
                last_rise = cyc; rises++;
            end
            prev_fld = field_id;
        end
        chk("R1 field rises seen", int'(rises >= 3), 1);
        for (int s = 0; s < 4; s++) begin
            wr(0, (s << 2) | 1);
            idle(140);
        end

        // stop and restart: flags return idle, counters restart at pixel 0 line 1
        wr(0, 32'h2);
        idle(20);
        wr(0, 32'h3);
        idle(150);

        // random configurations, some reprogrammed while running
        for (int ph = 0; ph < 30; ph++) begin
            rand_cfg((ph % 7) != 3);
            idle(400 + int'($urandom % 300));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule